// File: doc/BRIEF.md
# Link error threshold monitor

This block watches the error health of one serial link port. Each cycle it takes a bus of per-error-type detect pulses, a strobe that marks a retried packet, and a strobe that marks an accepted packet. It keeps two counters. The first is an error rate counter. Each enabled error pulse adds to it, and a programmable number of accepted packets leaks it back down. The second counter counts back-to-back retries. The rate counter is compared against a degraded limit and a failed limit. The retry counter is compared against its own limit.

When a counter rises above an armed limit, the block sets a sticky status flag. An enabled flag drives the level-sensitive interrupt. After a failed event, the port enters a hold. Control bits then choose one of three transmitter policies: keep sending, stop and keep queued packets, or stop and discard them. Software uses a small register interface. It programs the limits and enables, clears flags by writing 1 to them, and resets the rate counter. The rate counter reset also releases the hold.

Top module: `link_health_mon`

## Requirements
- R1: After reset, both counters, all status flags, `irq`, `txStop` and `txDiscard` are 0, and every register reads 0.
- R2: In each cycle the rate counter (STATUS[15:8]) adds the number of set bits in `errDetect & ERRMASK` (address 1). It saturates at 255, and masked-off error types have no effect.
- R3: LEAK (address 4) holds a period N. With N nonzero, every Nth accepted packet (`goodPkt`) lowers the rate counter by one, and the counter never goes below 0. N = 0 turns leaking off.
- R4: The degraded flag (STATUS bit 0) sets in the cycle the rate counter rises from at or below to above the degraded limit (RATE_THR[7:0], address 2). This happens only when that limit is nonzero and ERRMASK is nonzero. Reaching the limit without passing it does not set the flag.
- R5: The failed flag (STATUS bit 1) sets in the same way against the failed limit (RATE_THR[15:8]). The failed event also puts the port in the failed hold.
- R6: The retry counter (STATUS[23:16]) adds one on each `retryRcvd` and saturates at 255. It clears on a `goodPkt` with no retry in the same cycle. The retry flag (STATUS bit 2) sets when the counter rises above a nonzero RETRY_THR (address 3).
- R7: Writing to STATUS (address 5) clears each flag whose data bit in [2:0] is 1. Bits written as 0 leave their flags unchanged.
- R8: If a flag's set event and its clear write fall in the same cycle, the flag stays set.
- R9: `irq` is the OR of each flag ANDed with its enable, CTRL[4+i] for flag i. It stays high as long as an enabled flag is set.
- R10: In the failed hold, `txStop` equals CTRL[0] and `txDiscard` equals CTRL[0] AND CTRL[1]. Outside the hold both are 0. Clearing the failed flag does not release the hold.
- R11: Writing 1 to CTRL[2] zeroes the rate counter and the leak progress, and releases the failed hold. The bit itself is not stored.
- R12: These registers read back what was written: CTRL (bits 0, 1 and 6:4), ERRMASK, RATE_THR, RETRY_THR and LEAK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errDetect | input | NUM_ERR | One pulse bit per error type |
| retryRcvd | input | 1 | A retried packet was seen |
| goodPkt | input | 1 | A packet was accepted without retry |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Level interrupt |
| txStop | output | 1 | Transmitter must stop sending |
| txDiscard | output | 1 | Transmitter must drop queued packets |

## Verification
The assertions check, on every cycle, the links between pieces of logic. A datapath crossing event must set its flag. A flag may fall only after a status write. `txDiscard` never rises without `txStop`. The interrupt never rises without a flag. An accepted packet always clears the retry count, and a rate reset always releases the hold. The following can only be shown by the bench's scenarios: the exact count values, saturation and leak timing, the limit boundary (reaching versus passing), disarming by a zero limit, and the set-over-clear collision.

// File: rtl/lhm_pkg.sv
package lhm_pkg;
  typedef enum logic [2:0] {
    REG_CTRL      = 3'd0,
    REG_ERRMASK   = 3'd1,
    REG_RATE_THR  = 3'd2,
    REG_RETRY_THR = 3'd3,
    REG_LEAK      = 3'd4,
    REG_STATUS    = 3'd5
  } regAddr_e;

  localparam int FLG_DEG   = 0;
  localparam int FLG_FAIL  = 1;
  localparam int FLG_RETRY = 2;
  localparam int NUM_FLG   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic rateClr;
  } dpStrobe_t;
endpackage

// File: rtl/lhm_datapath.sv
module lhm_datapath
  import lhm_pkg::*;
#(
  parameter int NUM_ERR = 8,
  parameter int CNT_W   = 8,
  parameter int RETRY_W = 8,
  parameter int LEAK_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic [NUM_ERR-1:0] errDetect,
  input  logic [NUM_ERR-1:0] errMask,
  input  logic               retryRcvd,
  input  logic               goodPkt,
  input  logic [CNT_W-1:0]   degThr,
  input  logic [CNT_W-1:0]   failThr,
  input  logic [RETRY_W-1:0] retryThr,
  input  logic [LEAK_W-1:0]  leakPeriod,
  output logic [CNT_W-1:0]   rateCnt,
  output logic [RETRY_W-1:0] retryCnt,
  output logic               degEvt,
  output logic               failEvt,
  output logic               retryEvt
);
  localparam int INC_W = $clog2(NUM_ERR + 1);
  localparam int SUM_W = ((CNT_W > INC_W) ? CNT_W : INC_W) + 1;
  localparam logic [SUM_W-1:0] RATE_MAX = SUM_W'({CNT_W{1'b1}});
  localparam logic [RETRY_W-1:0] RETRY_MAX = {RETRY_W{1'b1}};

  logic [INC_W-1:0]   incAmt;
  logic [SUM_W-1:0]   rawSum;
  logic [CNT_W-1:0]   rateNext;
  logic [RETRY_W-1:0] retryNext;
  logic [LEAK_W-1:0]  leakCnt, leakNext;
  logic               leakOn, leakHit, rateArmed;

  assign incAmt  = INC_W'($countones(errDetect & errMask));
  assign leakOn  = goodPkt && (leakPeriod != '0);
  assign leakHit = leakOn && (leakCnt >= leakPeriod - 1'b1);

  always_comb begin
    rawSum = SUM_W'(rateCnt) + SUM_W'(incAmt);
    if (leakHit && rawSum != '0) rawSum = rawSum - 1'b1;
    rateNext = (rawSum > RATE_MAX) ? {CNT_W{1'b1}} : rawSum[CNT_W-1:0];
    if (strobe.rateClr) rateNext = '0;
  end

  always_comb begin
    leakNext = leakCnt;
    if (strobe.rateClr)  leakNext = '0;
    else if (leakHit)    leakNext = '0;
    else if (leakOn)     leakNext = leakCnt + 1'b1;
  end

  always_comb begin
    retryNext = retryCnt;
    if (retryRcvd) retryNext = (retryCnt == RETRY_MAX) ? RETRY_MAX : retryCnt + 1'b1;
    else if (goodPkt) retryNext = '0;
  end

  assign rateArmed = (errMask != '0);
  assign degEvt   = rateArmed && (degThr != '0) && (rateNext > degThr) && !(rateCnt > degThr);
  assign failEvt  = rateArmed && (failThr != '0) && (rateNext > failThr) && !(rateCnt > failThr);
  assign retryEvt = (retryThr != '0) && (retryNext > retryThr) && !(retryCnt > retryThr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateCnt  <= '0;
      retryCnt <= '0;
      leakCnt  <= '0;
    end else begin
      rateCnt  <= rateNext;
      retryCnt <= retryNext;
      leakCnt  <= leakNext;
    end
  end
endmodule

// File: rtl/lhm_control.sv
module lhm_control
  import lhm_pkg::*;
#(
  parameter int NUM_ERR = 8,
  parameter int CNT_W   = 8,
  parameter int RETRY_W = 8,
  parameter int LEAK_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [CNT_W-1:0]   rateCnt,
  input  logic [RETRY_W-1:0] retryCnt,
  input  logic               degEvt,
  input  logic               failEvt,
  input  logic               retryEvt,
  output dpStrobe_t          strobe,
  output logic [NUM_ERR-1:0] errMask,
  output logic [CNT_W-1:0]   degThr,
  output logic [CNT_W-1:0]   failThr,
  output logic [RETRY_W-1:0] retryThr,
  output logic [LEAK_W-1:0]  leakPeriod,
  output logic [NUM_FLG-1:0] flags,
  output logic               failHold,
  output logic               irq,
  output logic               txStop,
  output logic               txDiscard
);
  logic               stopOnFail, dropOnFail;
  logic [NUM_FLG-1:0] irqEn, setVec, clrVec;
  logic               wrCtrl, wrStatus;

  assign wrCtrl   = regWrEn && (regAddr == REG_CTRL);
  assign wrStatus = regWrEn && (regAddr == REG_STATUS);
  assign strobe.rateClr = wrCtrl && regWrData[2];

  assign setVec = {retryEvt, failEvt, degEvt};
  assign clrVec = wrStatus ? regWrData[NUM_FLG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopOnFail <= 1'b0;
      dropOnFail <= 1'b0;
      irqEn      <= '0;
      errMask    <= '0;
      degThr     <= '0;
      failThr    <= '0;
      retryThr   <= '0;
      leakPeriod <= '0;
      flags      <= '0;
      failHold   <= 1'b0;
    end else begin
      if (wrCtrl) begin
        stopOnFail <= regWrData[0];
        dropOnFail <= regWrData[1];
        irqEn      <= regWrData[4 +: NUM_FLG];
      end
      if (regWrEn && regAddr == REG_ERRMASK)   errMask    <= regWrData[NUM_ERR-1:0];
      if (regWrEn && regAddr == REG_RATE_THR) begin
        degThr  <= regWrData[0 +: CNT_W];
        failThr <= regWrData[8 +: CNT_W];
      end
      if (regWrEn && regAddr == REG_RETRY_THR) retryThr   <= regWrData[RETRY_W-1:0];
      if (regWrEn && regAddr == REG_LEAK)      leakPeriod <= regWrData[LEAK_W-1:0];
      // a new event beats a same-cycle clear
      flags <= setVec | (flags & ~clrVec);
      if (strobe.rateClr)  failHold <= 1'b0;
      else if (failEvt)    failHold <= 1'b1;
    end
  end

  assign irq       = |(flags & irqEn);
  assign txStop    = failHold && stopOnFail;
  assign txDiscard = txStop && dropOnFail;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      REG_CTRL: begin
        regRdData[0] = stopOnFail;
        regRdData[1] = dropOnFail;
        regRdData[4 +: NUM_FLG] = irqEn;
      end
      REG_ERRMASK:   regRdData[NUM_ERR-1:0] = errMask;
      REG_RATE_THR: begin
        regRdData[0 +: CNT_W] = degThr;
        regRdData[8 +: CNT_W] = failThr;
      end
      REG_RETRY_THR: regRdData[RETRY_W-1:0] = retryThr;
      REG_LEAK:      regRdData[LEAK_W-1:0]  = leakPeriod;
      REG_STATUS: begin
        regRdData[NUM_FLG-1:0]   = flags;
        regRdData[8 +: CNT_W]    = rateCnt;
        regRdData[16 +: RETRY_W] = retryCnt;
      end
      default: regRdData = '0;
    endcase
  end
endmodule

// File: rtl/link_health_mon.sv
module link_health_mon
  import lhm_pkg::*;
#(
  parameter int NUM_ERR = 8,
  parameter int CNT_W   = 8,
  parameter int RETRY_W = 8,
  parameter int LEAK_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_ERR-1:0] errDetect,
  input  logic               retryRcvd,
  input  logic               goodPkt,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irq,
  output logic               txStop,
  output logic               txDiscard
);
  dpStrobe_t          strobe;
  logic [NUM_ERR-1:0] errMask;
  logic [CNT_W-1:0]   degThr, failThr, rateCnt;
  logic [RETRY_W-1:0] retryThr, retryCnt;
  logic [LEAK_W-1:0]  leakPeriod;
  logic [NUM_FLG-1:0] flags;
  logic               failHold, degEvt, failEvt, retryEvt;

  lhm_datapath #(.NUM_ERR(NUM_ERR), .CNT_W(CNT_W), .RETRY_W(RETRY_W), .LEAK_W(LEAK_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .errDetect(errDetect), .errMask(errMask),
    .retryRcvd(retryRcvd), .goodPkt(goodPkt), .degThr(degThr), .failThr(failThr),
    .retryThr(retryThr), .leakPeriod(leakPeriod), .rateCnt(rateCnt), .retryCnt(retryCnt),
    .degEvt(degEvt), .failEvt(failEvt), .retryEvt(retryEvt)
  );

  lhm_control #(.NUM_ERR(NUM_ERR), .CNT_W(CNT_W), .RETRY_W(RETRY_W), .LEAK_W(LEAK_W),
                .DATA_W(DATA_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .rateCnt(rateCnt), .retryCnt(retryCnt), .degEvt(degEvt),
    .failEvt(failEvt), .retryEvt(retryEvt), .strobe(strobe), .errMask(errMask),
    .degThr(degThr), .failThr(failThr), .retryThr(retryThr), .leakPeriod(leakPeriod),
    .flags(flags), .failHold(failHold), .irq(irq), .txStop(txStop), .txDiscard(txDiscard)
  );
endmodule

// File: rtl/lhm_checker.sv
module lhm_checker
  import lhm_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 8,
  parameter int RETRY_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [2:0]         regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               goodPkt,
  input logic               retryRcvd,
  input logic               irq,
  input logic               txStop,
  input logic               txDiscard,
  input logic [NUM_FLG-1:0] flags,
  input logic               degEvt,
  input logic               failEvt,
  input logic [CNT_W-1:0]   rateCnt,
  input logic [RETRY_W-1:0] retryCnt
);
  // R4
  deg_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    degEvt |=> flags[FLG_DEG]);
  // R5
  fail_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    failEvt |=> flags[FLG_FAIL]);
  // R6
  retry_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodPkt && !retryRcvd) |=> (retryCnt == '0));
  // R7
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flags) & ~flags)) |-> $past(regWrEn && regAddr == REG_STATUS));
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (flags != '0));
  // R10
  discard_needs_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDiscard |-> txStop);
  // R11
  rate_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == REG_CTRL && regWrData[2]) |=> (!txStop && rateCnt == '0));
endmodule

bind link_health_mon lhm_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RETRY_W(RETRY_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .goodPkt(goodPkt), .retryRcvd(retryRcvd), .irq(irq), .txStop(txStop),
  .txDiscard(txDiscard), .flags(flags), .degEvt(degEvt), .failEvt(failEvt),
  .rateCnt(rateCnt), .retryCnt(retryCnt)
);

// File: tb/link_health_mon_tb_top.sv
`timescale 1ns/1ps
module link_health_mon_tb_top;
  localparam int NUM_ERR = 8;
  localparam logic [34:0] ALL  = {35{1'b1}};
  localparam logic [34:0] DATA = {3'b000, {32{1'b1}}};

  typedef struct {
    logic [34:0] exp;
    logic [34:0] mask;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_ERR-1:0] errDetect = '0;
  logic retryRcvd = 1'b0, goodPkt = 1'b0, regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irq, txStop, txDiscard;
  logic rdValid = 1'b0;
  item_t sbQ[$];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  link_health_mon dut_i (
    .clk(clk), .rstN(rstN), .errDetect(errDetect), .retryRcvd(retryRcvd), .goodPkt(goodPkt),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .txStop(txStop), .txDiscard(txDiscard)
  );

  // monitor: pops expected items and compares away from the clock edge
  always @(negedge clk) begin
    if (rdValid) begin
      item_t it;
      logic [34:0] act;
      act = {irq, txDiscard, txStop, regRdData};
      checks++;
      if (sbQ.size() == 0) begin
        errors++;
        $display("FAIL %s: no expected item, actual %h", "scoreboard", act);
      end else begin
        it = sbQ.pop_front();
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: actual {irq,disc,stop,data}=%h expected %h", it.tag,
                   act & it.mask, it.exp & it.mask);
        end
      end
    end
  end

  task automatic expectRd(input logic [2:0] a, input logic [31:0] data, input logic i,
                          input logic d, input logic s, input logic [34:0] m, input string tag);
    item_t it;
    it.exp = {i, d, s, data}; it.mask = m; it.tag = tag;
    sbQ.push_back(it);
    regAddr = a; rdValid = 1'b1;
    @(posedge clk); #1;
    rdValid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic errPulse(input logic [NUM_ERR-1:0] v);
    errDetect = v;
    @(posedge clk); #1;
    errDetect = '0;
  endtask

  task automatic goodPulse();
    goodPkt = 1'b1;
    @(posedge clk); #1;
    goodPkt = 1'b0;
  endtask

  task automatic retryPulse();
    retryRcvd = 1'b1;
    @(posedge clk); #1;
    retryRcvd = 1'b0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    expectRd(5, 32'h0, 0, 0, 0, ALL, "R1 status after reset");
    expectRd(0, 32'h0, 0, 0, 0, ALL, "R1 ctrl after reset");
    // configuration and readback
    wr(1, 32'h0F);
    wr(2, 32'h0603);
    wr(0, 32'h71);
    expectRd(2, 32'h0603, 0, 0, 0, DATA, "R12 rate thresholds readback");
    expectRd(0, 32'h71, 0, 0, 0, DATA, "R12 ctrl readback");
    // R2 masked type ignored
    errPulse(8'h10);
    expectRd(5, 32'h0, 0, 0, 0, ALL, "R2 masked error ignored");
    errPulse(8'h03);
    errPulse(8'h01);
    expectRd(5, 32'h0300, 0, 0, 0, ALL, "R4 equal to limit does not set");
    errPulse(8'h01);
    expectRd(5, 32'h0401, 1, 0, 0, ALL, "R4 degraded set above limit");
    // R7 write-one-to-clear
    wr(5, 32'h0);
    expectRd(5, 32'h0401, 1, 0, 0, ALL, "R7 write zero keeps flag");
    wr(5, 32'h1);
    expectRd(5, 32'h0400, 0, 0, 0, ALL, "R9 irq drops after clear");
    // R3 leak
    wr(4, 32'h2);
    goodPulse();
    expectRd(5, 32'h0400, 0, 0, 0, ALL, "R3 no leak before period");
    goodPulse();
    expectRd(5, 32'h0300, 0, 0, 0, ALL, "R3 leak after period");
    // R5 failed threshold and R10 policy
    errPulse(8'h0F);
    expectRd(5, 32'h0703, 1, 0, 1, ALL, "R5 failed set, stop without drop");
    wr(0, 32'h73);
    expectRd(5, 32'h0703, 1, 1, 1, ALL, "R10 drop policy");
    wr(5, 32'h2);
    expectRd(5, 32'h0701, 1, 1, 1, ALL, "R10 hold survives flag clear");
    // R11 rate reset releases hold
    wr(0, 32'h77);
    expectRd(5, 32'h0001, 1, 0, 0, ALL, "R11 rate reset releases hold");
    expectRd(0, 32'h73, 1, 0, 0, ALL, "R11 reset bit not stored");
    // R2 saturation
    wr(1, 32'hFF);
    for (int k = 0; k < 40; k++) errPulse(8'hFF);
    expectRd(5, 32'hFF03, 1, 1, 1, ALL, "R2 rate saturates at 255");
    // R8 set beats clear
    wr(0, 32'h77);
    wr(5, 32'h7);
    expectRd(5, 32'h0, 0, 0, 0, ALL, "R7 all flags cleared");
    errDetect = 8'hFF; regWrEn = 1'b1; regAddr = 3'd5; regWrData = 32'h3;
    @(posedge clk); #1;
    errDetect = '0; regWrEn = 1'b0; regWrData = '0;
    expectRd(5, 32'h0803, 1, 1, 1, ALL, "R8 set wins over same-cycle clear");
    // R4 zero degraded limit disarms
    wr(0, 32'h77);
    wr(5, 32'h7);
    wr(2, 32'h0600);
    errPulse(8'h0F);
    expectRd(5, 32'h0400, 0, 0, 0, ALL, "R4 zero limit disarms degraded");
    // R6 retry counter
    wr(3, 32'h2);
    retryPulse();
    retryPulse();
    expectRd(5, 32'h020400, 0, 0, 0, ALL, "R6 retry at limit no flag");
    retryPulse();
    expectRd(5, 32'h030404, 1, 0, 0, ALL, "R6 retry flag above limit");
    goodPulse();
    expectRd(5, 32'h000404, 1, 0, 0, ALL, "R6 good packet clears retry count");
    for (int k = 0; k < 300; k++) retryPulse();
    expectRd(5, 32'hFF0404, 1, 0, 0, ALL, "R6 retry count saturates");
    // R9 enables off
    wr(0, 32'h03);
    expectRd(5, 32'hFF0404, 0, 0, 0, ALL, "R9 irq masked by enables");
    // R3 floor at zero
    wr(0, 32'h07);
    wr(4, 32'h1);
    goodPulse();
    expectRd(5, 32'h000004, 0, 0, 0, ALL, "R3 leak floors at zero");
    @(posedge clk); #1;
    if (sbQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: %0d items left, expected 0", sbQ.size());
    end
    report();
  end
endmodule